// File: doc/BRIEF.md
# Serial Core State and Status Controller

This block is the control and status front end of a serial bus engine. It holds a two-bit operating state (reset, run or pause) and a valid indicator. Any state change, and any software reset, clears the valid indicator for a settling window. The window spans a fixed number of host clocks followed by a fixed number of serial-clock ticks. Software requests a state by writing its code while valid is set, then polls until it reads the same code back with valid set. A write attempted while the block is settling is refused and leaves a sticky mark.

The block passes run, pause and flush controls to the datapath. The datapath sends back event pulses for output service, input service, NACK, bus error and two core errors. Each event is held in a flag that software clears by writing 1 to it. A mask selects which held flags raise the level interrupt. Writing the reset code while no transfer is in progress also clears the pending error flags. A single word-wide register port gives software access to all of it. Reads are combinational and writes take effect at the clock edge.

Top module: `serial_core_ctrl`

## Requirements
- R1: After rst_n is held low over a clock edge, the state register at address 0 reads 0x4 (code 0, valid bit 2 set). Addresses 2 to 5 read 0. run_o, pause_o, flush_o and irq_o are low.
- R2: A write to address 0 with bit 6 clear, valid set and bits [1:0] equal to 0 (reset), 1 (run) or 3 (pause) is accepted. Valid reads 0 from the next cycle on.
- R3: After an accepted change, valid stays low for HOST_SETTLE clocks and then until SER_SETTLE ser_tick pulses have been seen. On the edge of the last of those pulses, valid returns and the new code becomes visible at bits [1:0]. run_o is high exactly while the visible code is 1, and pause_o exactly while it is 3.
- R4: A write to address 0 with bit 6 clear is ignored if valid is low or if bits [1:0] equal 2. It sets the sticky illegal bit 7 of address 0, which only reset or software reset clears.
- R5: A write to address 0 with bit 6 set gives a one-cycle flush_o pulse on the next cycle, whatever the state of valid. It leaves the code, valid and the illegal bit unchanged. Bit 6 always reads 0.
- R6: Writing a 1 in bit 0 of address 1 sets the code to 0 and clears all event flags and the illegal bit, from the next cycle. It also drops valid and starts the settling window. The mask is kept. Writing 0 there has no effect.
- R7: An output-service event sets bit 8 and an input-service event sets bit 9 of address 2. Writing 1 to either bit clears it. An event in the same cycle as the clear wins.
- R8: At address 3, a NACK event sets bit 3 and a bus-error event sets bit 4. At address 4, core-error events set bits [1:0]. All of these are cleared by writing 1, and an event in the same cycle wins.
- R9: An accepted write of code 0 while xfer_active is low clears the flags at addresses 3 and 4, except where an event arrives in the same cycle. With xfer_active high, those flags are kept.
- R10: Address 5 holds a mask: bit 0 output service, bit 1 input service, bit 2 NACK, bit 3 bus error, bits 4 and 5 core errors. irq_o is high exactly when some held flag has its mask bit set. It follows a flag change with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (read and write) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| evt_out_svc | input | 1 | Output-service event pulse |
| evt_in_svc | input | 1 | Input-service event pulse |
| evt_nack | input | 1 | NACK event pulse |
| evt_bus_err | input | 1 | Bus error event pulse |
| evt_core_err | input | 2 | Core error event pulses |
| xfer_active | input | 1 | A bus transfer is in progress |
| ser_tick | input | 1 | One pulse per serial-master clock |
| run_o | output | 1 | Datapath run control |
| pause_o | output | 1 | Datapath pause control |
| flush_o | output | 1 | Flush request pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
If the settling counter ends early or hangs, the valid bit at address 0 rises in the wrong cycle or never rises. A refused write then fails to mark the illegal bit, or an accepted one is lost. Both show on the next read of address 0. A flag that latches or clears in the wrong cycle changes irq_o in the following cycle whenever its mask bit is set. Because the bench tracks every cycle and reads a random address on each one, a wrong state is normally seen within a few cycles of its cause.

// File: rtl/serial_core_pkg.sv
// Shared encodings for the serial core controller.
// Assumes a word-addressed register port; flag indices are fixed by the mask layout.
package serial_core_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } state_code_t;

    localparam int NUM_FLAGS = 6;

    // Word addresses
    localparam int A_STATE = 0;
    localparam int A_SWRST = 1;
    localparam int A_OPER  = 2;
    localparam int A_BUS   = 3;
    localparam int A_CORE  = 4;
    localparam int A_MASK  = 5;

    // Bit positions in the state register
    localparam int B_VALID   = 2;
    localparam int B_FLUSH   = 6;
    localparam int B_ILLEGAL = 7;

    // Flag indices (also mask bit positions)
    localparam int F_OUT_SVC = 0;
    localparam int F_IN_SVC  = 1;
    localparam int F_NACK    = 2;
    localparam int F_BUS_ERR = 3;
    localparam int F_CORE0   = 4;
    localparam int F_CORE1   = 5;

endpackage

// File: rtl/serial_core_settle.sv
// Settling timer: after start, waits HOST_SETTLE clocks, then SER_SETTLE ser_tick
// pulses. busy_o is high for the whole window; done_o marks its last cycle.
// Assumes HOST_SETTLE >= 1 and SER_SETTLE >= 1; a start restarts the window.
module serial_core_settle #(
    parameter int HOST_SETTLE = 3,
    parameter int SER_SETTLE  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ser_tick_i,
    output logic busy_o,
    output logic done_o
);
    localparam int HW = (HOST_SETTLE > 1) ? $clog2(HOST_SETTLE) : 1;
    localparam int SW = (SER_SETTLE > 1) ? $clog2(SER_SETTLE) : 1;

    logic [HW-1:0] hcnt;
    logic [SW-1:0] scnt;
    logic          in_ser;
    logic          busy;

    // Last serial tick of the window
    assign done_o = busy && in_ser && ser_tick_i && (scnt == SW'(SER_SETTLE - 1));
    assign busy_o = busy;

    // Two-phase window counter: host clocks first, then serial ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            in_ser <= 1'b0;
            hcnt   <= '0;
            scnt   <= '0;
        end else if (start_i) begin
            busy   <= 1'b1;
            in_ser <= 1'b0;
            hcnt   <= '0;
            scnt   <= '0;
        end else if (busy) begin
            if (!in_ser) begin
                if (hcnt == HW'(HOST_SETTLE - 1)) in_ser <= 1'b1;
                else                               hcnt   <= hcnt + 1'b1;
            end else if (ser_tick_i) begin
                if (done_o) busy <= 1'b0;
                else        scnt <= scnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_core_state.sv
// Operating state holder: accepts state writes only while not settling,
// records refused writes, issues flush pulses, applies software reset.
// Assumes the caller decodes the register address into wr_state_i and swrst_i.
module serial_core_state
    import serial_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_state_i,
    input  logic [1:0]  wr_code_i,
    input  logic        wr_flush_i,
    input  logic        swrst_i,
    input  logic        busy_i,
    input  logic        done_i,
    output state_code_t act_code_o,
    output logic        illegal_o,
    output logic        flush_o,
    output logic        start_o,
    output logic        accept_reset_o
);
    state_code_t req_code;
    state_code_t act_code;
    logic        illegal;
    logic        flush_q;
    logic        accept;
    logic        refuse;

    // Classify a state-register write
    always_comb begin
        accept = wr_state_i && !wr_flush_i && !busy_i && (wr_code_i != 2'd2);
        refuse = wr_state_i && !wr_flush_i && (busy_i || (wr_code_i == 2'd2));
    end

    assign start_o        = accept || swrst_i;
    assign accept_reset_o = accept && (wr_code_i == 2'd0);
    assign act_code_o     = act_code;
    assign illegal_o      = illegal;
    assign flush_o        = flush_q;

    // Requested/applied code, sticky refusal mark and flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_code <= ST_RESET;
            act_code <= ST_RESET;
            illegal  <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            flush_q <= wr_state_i && wr_flush_i && !swrst_i;
            if (swrst_i) begin
                req_code <= ST_RESET;
                act_code <= ST_RESET;
                illegal  <= 1'b0;
            end else begin
                if (accept) req_code <= state_code_t'(wr_code_i);
                if (refuse) illegal  <= 1'b1;
                if (done_i) act_code <= req_code;
            end
        end
    end
endmodule

// File: rtl/serial_core_flags.sv
// Bank of event flags: a set pulse latches a bit, a clear vector drops it,
// clr_all drops every bit. Priority: clr_all, then set, then clear.
module serial_core_flags #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One flag bit with set-over-clear priority
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all_i) flags_o[i] <= 1'b0;
            else if (set_i[i])       flags_o[i] <= 1'b1;
            else if (clr_i[i])       flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_core_ctrl.sv
// Top of the serial core controller: register decode, read mux, interrupt.
// Assumes DATA_W >= 10 and ADDR_W >= 3; unmapped reads return 0.
module serial_core_ctrl
    import serial_core_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int HOST_SETTLE = 3,
    parameter int SER_SETTLE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              evt_out_svc,
    input  logic              evt_in_svc,
    input  logic              evt_nack,
    input  logic              evt_bus_err,
    input  logic [1:0]        evt_core_err,
    input  logic              xfer_active,
    input  logic              ser_tick,
    output logic              run_o,
    output logic              pause_o,
    output logic              flush_o,
    output logic              irq_o
);
    logic                 wr_state, swrst;
    logic                 busy, done, start, accept_reset, illegal;
    state_code_t          act_code;
    logic [NUM_FLAGS-1:0] flags, set_v, clr_v;
    logic [NUM_FLAGS-1:0] mask;
    logic                 st_valid;

    // Write strobes for the state and soft-reset registers
    always_comb begin
        wr_state = reg_wr && (reg_addr == ADDR_W'(A_STATE));
        swrst    = reg_wr && (reg_addr == ADDR_W'(A_SWRST)) && reg_wdata[0];
    end

    assign st_valid = !busy;

    serial_core_settle #(.HOST_SETTLE(HOST_SETTLE), .SER_SETTLE(SER_SETTLE)) i_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .ser_tick_i (ser_tick),
        .busy_o     (busy),
        .done_o     (done)
    );

    serial_core_state i_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_state_i     (wr_state),
        .wr_code_i      (reg_wdata[1:0]),
        .wr_flush_i     (reg_wdata[B_FLUSH]),
        .swrst_i        (swrst),
        .busy_i         (busy),
        .done_i         (done),
        .act_code_o     (act_code),
        .illegal_o      (illegal),
        .flush_o        (flush_o),
        .start_o        (start),
        .accept_reset_o (accept_reset)
    );

    // Gather event pulses into flag order
    always_comb begin
        set_v            = '0;
        set_v[F_OUT_SVC] = evt_out_svc;
        set_v[F_IN_SVC]  = evt_in_svc;
        set_v[F_NACK]    = evt_nack;
        set_v[F_BUS_ERR] = evt_bus_err;
        set_v[F_CORE0]   = evt_core_err[0];
        set_v[F_CORE1]   = evt_core_err[1];
    end

    // Write-one-to-clear decode plus error clear on an idle reset-code write
    always_comb begin
        clr_v = '0;
        if (reg_wr && reg_addr == ADDR_W'(A_OPER)) begin
            clr_v[F_OUT_SVC] = reg_wdata[8];
            clr_v[F_IN_SVC]  = reg_wdata[9];
        end
        if (reg_wr && reg_addr == ADDR_W'(A_BUS)) begin
            clr_v[F_NACK]    = reg_wdata[3];
            clr_v[F_BUS_ERR] = reg_wdata[4];
        end
        if (reg_wr && reg_addr == ADDR_W'(A_CORE)) begin
            clr_v[F_CORE0]   = reg_wdata[0];
            clr_v[F_CORE1]   = reg_wdata[1];
        end
        if (accept_reset && !xfer_active) begin
            clr_v[F_NACK]    = 1'b1;
            clr_v[F_BUS_ERR] = 1'b1;
            clr_v[F_CORE0]   = 1'b1;
            clr_v[F_CORE1]   = 1'b1;
        end
    end

    serial_core_flags #(.WIDTH(NUM_FLAGS)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all_i (swrst),
        .set_i     (set_v),
        .clr_i     (clr_v),
        .flags_o   (flags)
    );

    // Interrupt mask register; survives software reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                    mask <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(A_MASK)) mask <= reg_wdata[NUM_FLAGS-1:0];
    end

    // Datapath controls and interrupt level
    always_comb begin
        run_o   = (act_code == ST_RUN);
        pause_o = (act_code == ST_PAUSE);
        irq_o   = |(flags & mask);
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_STATE): begin
                reg_rdata[1:0]       = act_code;
                reg_rdata[B_VALID]   = st_valid;
                reg_rdata[B_ILLEGAL] = illegal;
            end
            ADDR_W'(A_OPER): begin
                reg_rdata[8] = flags[F_OUT_SVC];
                reg_rdata[9] = flags[F_IN_SVC];
            end
            ADDR_W'(A_BUS): begin
                reg_rdata[3] = flags[F_NACK];
                reg_rdata[4] = flags[F_BUS_ERR];
            end
            ADDR_W'(A_CORE): begin
                reg_rdata[0] = flags[F_CORE0];
                reg_rdata[1] = flags[F_CORE1];
            end
            ADDR_W'(A_MASK): reg_rdata[NUM_FLAGS-1:0] = mask;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_core_ctrl_chk.sv
// Checker for serial_core_ctrl; attached by bind below.
// Assumes the default register layout of serial_core_pkg.
module serial_core_ctrl_chk #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int HOST_SETTLE = 3,
    parameter int SER_SETTLE  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              evt_out_svc,
    input logic              st_valid,
    input logic [1:0]        act_code,
    input logic              illegal,
    input logic [5:0]        flags,
    input logic [5:0]        mask,
    input logic              run_o,
    input logic              pause_o,
    input logic              flush_o,
    input logic              irq_o
);
    logic [7:0] lowcnt;
    logic       wr_st, wr_sr;

    assign wr_st = reg_wr && (reg_addr == ADDR_W'(0)) && !reg_wdata[6];
    assign wr_sr = reg_wr && (reg_addr == ADDR_W'(1)) && reg_wdata[0];

    // Count cycles with valid low (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || st_valid) lowcnt <= '0;
        else if (lowcnt != 8'hff) lowcnt <= lowcnt + 1'b1;
    end

    AST_ACCEPT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && st_valid && reg_wdata[1:0] != 2'd2) |=> !st_valid); // R2
    AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> (lowcnt >= 8'(HOST_SETTLE + SER_SETTLE))); // R3
    AST_RUN_PAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_o && pause_o)); // R3
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !st_valid && !wr_sr) |=> illegal); // R4
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && st_valid && reg_wdata[1:0] == 2'd2) |=> (illegal && $stable(act_code) && st_valid)); // R4
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[6])); // R5
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sr |=> (!irq_o && !run_o && !pause_o && !st_valid && !illegal)); // R6
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out_svc && !wr_sr) |=> flags[0]); // R7
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 6'd0) |-> !irq_o); // R10
endmodule

bind serial_core_ctrl serial_core_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_SETTLE(HOST_SETTLE), .SER_SETTLE(SER_SETTLE)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .evt_out_svc (evt_out_svc),
    .st_valid    (st_valid),
    .act_code    (act_code),
    .illegal     (illegal),
    .flags       (flags),
    .mask        (mask),
    .run_o       (run_o),
    .pause_o     (pause_o),
    .flush_o     (flush_o),
    .irq_o       (irq_o)
);

// File: tb/test_serial_core_ctrl.sv
// Bench: directed corner cases then seeded random traffic, compared every
// cycle with a reference model written from the requirements.
module test_serial_core_ctrl;
    localparam int H = 3;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  ev = '0;
    logic        xfer_active = 1'b0;
    logic        ser_tick = 1'b1;
    logic        run_o, pause_o, flush_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_core_ctrl i_serial_core_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_out_svc  (ev[0]),
        .evt_in_svc   (ev[1]),
        .evt_nack     (ev[2]),
        .evt_bus_err  (ev[3]),
        .evt_core_err (ev[5:4]),
        .xfer_active  (xfer_active),
        .ser_tick     (ser_tick),
        .run_o        (run_o),
        .pause_o      (pause_o),
        .flush_o      (flush_o),
        .irq_o        (irq_o)
    );

    // Reference model state
    logic [1:0] m_act, m_req;
    logic       m_busy, m_inser, m_ill, m_flush;
    int         m_hcnt, m_scnt;
    logic [5:0] m_flags, m_mask;

    // Model update per clock edge, from the requirements
    always @(posedge clk) begin
        logic st, sw, acc, refuse, done;
        logic [5:0] clr;
        if (!rst_n) begin
            m_act = 0; m_req = 0; m_busy = 0; m_inser = 0; m_ill = 0; m_flush = 0;
            m_hcnt = 0; m_scnt = 0; m_flags = 0; m_mask = 0;
        end else begin
            st     = reg_wr && reg_addr == 3'd0 && !reg_wdata[6];
            sw     = reg_wr && reg_addr == 3'd1 && reg_wdata[0];
            acc    = st && !m_busy && reg_wdata[1:0] != 2'd2;
            refuse = st && (m_busy || reg_wdata[1:0] == 2'd2);
            done   = m_busy && m_inser && ser_tick && m_scnt == S - 1;
            clr = 0;
            if (reg_wr && reg_addr == 3'd2) clr[1:0] = reg_wdata[9:8];
            if (reg_wr && reg_addr == 3'd3) clr[3:2] = reg_wdata[4:3];
            if (reg_wr && reg_addr == 3'd4) clr[5:4] = reg_wdata[1:0];
            if (acc && reg_wdata[1:0] == 2'd0 && !xfer_active) clr[5:2] = 4'hf;
            m_flush = reg_wr && reg_addr == 3'd0 && reg_wdata[6] && !sw;
            for (int i = 0; i < 6; i++)
                if (sw) m_flags[i] = 0;
                else if (ev[i]) m_flags[i] = 1;
                else if (clr[i]) m_flags[i] = 0;
            if (reg_wr && reg_addr == 3'd5) m_mask = reg_wdata[5:0];
            if (sw) begin
                m_act = 0; m_req = 0; m_ill = 0;
            end else begin
                if (acc) m_req = reg_wdata[1:0];
                if (refuse) m_ill = 1;
                if (done) m_act = m_req;
            end
            if (acc || sw) begin
                m_busy = 1; m_inser = 0; m_hcnt = 0; m_scnt = 0;
            end else if (m_busy) begin
                if (!m_inser) begin
                    if (m_hcnt == H - 1) m_inser = 1; else m_hcnt++;
                end else if (ser_tick) begin
                    if (m_scnt == S - 1) m_busy = 0; else m_scnt++;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] r = 0;
        case (a)
            3'd0: begin r[1:0] = m_act; r[2] = !m_busy; r[7] = m_ill; end
            3'd2: r[9:8] = m_flags[1:0];
            3'd3: r[4:3] = m_flags[3:2];
            3'd4: r[1:0] = m_flags[5:4];
            3'd5: r[5:0] = m_mask;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2 R3 R4 state";
            3'd1: return "R6 swrst";
            3'd2: return "R7 oper";
            3'd3: return "R8 R9 bus";
            3'd4: return "R8 R9 core";
            3'd5: return "R10 mask";
            default: return "R2 unmapped";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
        chk("R3 run_o", {31'd0, run_o}, {31'd0, m_act == 2'd1});
        chk("R3 pause_o", {31'd0, pause_o}, {31'd0, m_act == 2'd3});
        chk("R5 flush_o", {31'd0, flush_o}, {31'd0, m_flush});
        chk("R10 irq_o", {31'd0, irq_o}, {31'd0, |(m_flags & m_mask)});
    endtask

    // One cycle: compare previous results, then drive new inputs
    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [5:0] e, input logic t, input logic x);
        @(negedge clk);
        if (cmp_en) compare_all();
        reg_wr = w; reg_addr = a; reg_wdata = d; ev = e; ser_tick = t; xfer_active = x;
    endtask

    task automatic idle(input int n, input logic [2:0] a);
        for (int i = 0; i < n; i++) cyc(0, a, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, with constants
        reg_addr = 3'd0; #1; chk("R1 state", reg_rdata, 32'h4);
        for (int a = 2; a < 6; a++) begin
            reg_addr = 3'(a); #1; chk("R1 flags/mask", reg_rdata, 0);
        end
        chk("R1 outputs", {28'd0, run_o, pause_o, flush_o, irq_o}, 0);
        cmp_en = 1;
        // R2/R3: go to run, tick every cycle
        cyc(1, 0, 32'h1, 0, 1, 0);
        idle(8, 0);
        // R4: write during settle, then code 2
        cyc(1, 0, 32'h3, 0, 1, 0);
        cyc(1, 0, 32'h0, 0, 1, 0);
        idle(3, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, i[0], 0);  // sparse ticks
        cyc(1, 0, 32'h2, 0, 1, 0);
        idle(2, 0);
        // R5: flush while settling and while stable
        cyc(1, 0, 32'h1, 0, 1, 0);
        cyc(1, 0, 32'h40, 0, 1, 0);
        idle(8, 0);
        cyc(1, 0, 32'h43, 0, 1, 0);
        idle(2, 0);
        // R10/R7/R8: mask all, raise events, clear, set-wins
        cyc(1, 5, 32'h3f, 0, 1, 0);
        cyc(0, 2, 0, 6'h3f, 1, 0);
        idle(1, 3);
        cyc(1, 2, 32'h100, 6'h01, 1, 0);
        idle(1, 2);
        cyc(1, 2, 32'h200, 0, 1, 0);
        idle(1, 2);
        cyc(1, 3, 32'h18, 0, 1, 0);
        idle(1, 3);
        // R9: reset-code write with transfer active keeps errors, idle clears
        cyc(0, 0, 0, 6'h3c, 1, 0);
        cyc(1, 0, 32'h0, 0, 1, 1);
        idle(7, 4);
        cyc(1, 0, 32'h0, 0, 1, 0);
        idle(7, 3);
        // R6: software reset from run
        cyc(1, 0, 32'h1, 0, 1, 0);
        idle(7, 0);
        cyc(0, 0, 0, 6'h3f, 1, 0);
        cyc(1, 1, 32'h0, 0, 1, 0);
        cyc(1, 1, 32'h1, 0, 1, 0);
        @(negedge clk);
        compare_all();
        chk("R6 state after swrst", reg_rdata, 32'h0);
        chk("R6 irq after swrst", {31'd0, irq_o}, 0);
        reg_wr = 0;
        idle(8, 5);
        // Random traffic
        for (int n = 0; n < 6000; n++) begin
            logic [2:0]  a;
            logic [31:0] d;
            logic        w;
            logic [5:0]  e;
            w = ($urandom_range(0, 2) == 0);
            a = 3'($urandom_range(0, 6));
            if (a == 3'd1 && $urandom_range(0, 9) != 0) a = 3'd0;
            d = $urandom;
            if (a == 3'd0) d = {25'd0, ($urandom_range(0, 7) == 0), 4'd0, 2'($urandom)};
            e = 0;
            for (int i = 0; i < 6; i++) e[i] = ($urandom_range(0, 11) == 0);
            cyc(w, a, d, e, ($urandom_range(0, 3) != 0), ($urandom_range(0, 1) == 0));
        end
        idle(2, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule